// File: doc/BRIEF.md
# Bit, Rotate and Shift Unit

This execution unit serves the prefixed bit-manipulation opcode space of an 8-bit processor core. It also serves the four short accumulator rotates. Each operation is one opcode byte plus a flag that says whether the byte came from the prefixed space. With the opcode come the current register operand, the current flags and the 16-bit pointer used for indirect operands. The unit returns a result byte, a register write strobe, the register code to write and a new flag nibble with its own write strobe.

For a register operand the answer appears one cycle after `start`. When the register code selects memory, a small controller sequences the access. It spends one cycle reading the byte at the pointer and one cycle operating on it. It then spends one cycle either storing the result back or, for a bit test, idling. A final cycle signals completion. While an operation is in flight the unit reports `busy` and ignores new requests. The register file and the memory itself live outside the block.

Top module: `bit_shift_unit`

## Requirements
- R1: A prefixed opcode is split as follows. Bits [7:6] give the class: 0 = rotate/shift, 1 = bit test, 2 = bit clear, 3 = bit set. Bits [5:3] give the bit index, or the shift kind for class 0. Bits [2:0] give the register code, and code 6 means the memory byte at `hl_addr`. `reg_sel` reports bits [2:0] at completion.
- R2: The rotate kinds are 0 = circular left, 1 = circular right, 2 = left through carry and 3 = right through carry. Circular left copies the old bit 7 into bit 0 and into C. Circular right copies the old bit 0 into bit 7 and into C. Left through carry puts the old C into bit 0 and the old bit 7 into C. Right through carry puts the old C into bit 7 and the old bit 0 into C.
- R3: The shift kinds are 4 = arithmetic left, 5 = arithmetic right, 6 = nibble swap and 7 = logical right. Arithmetic left moves bit 7 into C and fills bit 0 with zero. Arithmetic right moves bit 0 into C and keeps bit 7. Logical right moves bit 0 into C and fills bit 7 with zero. Nibble swap exchanges the two halves and clears C.
- R4: The flag nibble `flags_out` is laid out as {Z, N, H, C}, with Z in bit 3. Every class-0 operation writes flags with Z = (result == 0), N = 0 and H = 0.
- R5: A bit test sets Z to the inverse of the selected bit, N = 0 and H = 1, and keeps C. It never writes the register and never writes memory, even for code 6.
- R6: Bit clear and bit set force only the selected bit and leave every other bit unchanged. They assert no flag write, and `flags_out` equals the incoming flags.
- R7: With `prefixed` = 0, the opcode is an accumulator rotate. Bits [4:3] pick kind 0..3 with the R2 meaning, and the register code is bits [2:0]. Z is forced to 0 whatever the result, and N and H are cleared.
- R8: A memory operand follows a fixed sequence after the start edge. In cycle 1, `mem_rd` is high with `mem_addr` = pointer. The byte arrives in cycle 2. In cycle 3, `mem_wr` is high with the result on `mem_wdata`, except that a bit test idles with no strobe. In cycle 4, `done` is high with `reg_we` = 0. Read and write are never high together.
- R9: A register operand gives `done`, `result`, `reg_we` = 1 (0 for a bit test), `flags_out` and `flags_we` in the cycle after the start edge. `done` lasts one cycle.
- R10: A `start` that arrives while `busy` is high is ignored and produces no further completion.
- R11: After synchronous reset the unit is idle, with `busy`, `done`, `mem_rd`, `mem_wr`, `reg_we` and `flags_we` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request an operation (taken only when idle) |
| prefixed | input | 1 | 1 = prefixed opcode space, 0 = accumulator rotate |
| opcode | input | 8 | Operation byte |
| reg_data | input | 8 | Register operand value |
| hl_addr | input | ADDR_W | Pointer for the memory operand |
| flags_in | input | 4 | Current flags {Z,N,H,C} |
| mem_addr | output | ADDR_W | Memory address |
| mem_rd | output | 1 | Memory read strobe; data expected next cycle |
| mem_rdata | input | 8 | Memory read data |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| busy | output | 1 | Operation in flight |
| done | output | 1 | One-cycle completion pulse |
| result | output | 8 | Result byte |
| reg_we | output | 1 | Write `result` to register `reg_sel` |
| reg_sel | output | 3 | Destination register code |
| flags_out | output | 4 | New flags {Z,N,H,C} |
| flags_we | output | 1 | Write `flags_out` |

## Verification
The bench targets the carry edges where a wrong design swaps bits. Feeding 0x80 and 0x01 through each rotate catches a design that mixes up the circular and through-carry forms, because it would lose or duplicate the carry bit. Zero results are compared between the accumulator rotate and its prefixed twin: a design that shares their flag logic would raise Z on the accumulator form. A bit test on a memory operand checks that no write strobe appears, and that no register write appears either. A start pulse delivered mid-sequence catches a controller that re-arms early, which would show up as a second completion.

// File: rtl/bsu_pkg.sv
package bsu_pkg;

    localparam int BYTE_W   = 8;
    localparam int FLAG_W   = 4;
    localparam logic [2:0] MEM_CODE = 3'd6;

    typedef enum logic [1:0] {
        CLS_SHIFT = 2'd0,
        CLS_TEST  = 2'd1,
        CLS_CLEAR = 2'd2,
        CLS_SET   = 2'd3
    } op_class_e;

    typedef enum logic [2:0] {
        SK_RLC  = 3'd0,
        SK_RRC  = 3'd1,
        SK_RL   = 3'd2,
        SK_RR   = 3'd3,
        SK_SLA  = 3'd4,
        SK_SRA  = 3'd5,
        SK_SWAP = 3'd6,
        SK_SRL  = 3'd7
    } shift_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_LOAD, ST_EXEC, ST_STORE, ST_STALL, ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } flags_t;

    typedef struct packed {
        op_class_e  cls;
        logic [2:0] sel;
        logic [2:0] reg_code;
        logic       acc_mode;
        logic       use_mem;
    } op_t;

    typedef struct packed {
        logic [BYTE_W-1:0] value;
        logic              write;
        flags_t            flags;
        logic              flags_we;
    } exec_t;

    // Returns {carry_out, value_out}
    function automatic logic [BYTE_W:0] shift_byte(
        input shift_kind_e kind,
        input logic [BYTE_W-1:0] v,
        input logic cin
    );
        logic [BYTE_W:0] r;
        case (kind)
            SK_RLC:  r = {v[7], v[6:0], v[7]};
            SK_RRC:  r = {v[0], v[0], v[7:1]};
            SK_RL:   r = {v[7], v[6:0], cin};
            SK_RR:   r = {v[0], cin, v[7:1]};
            SK_SLA:  r = {v[7], v[6:0], 1'b0};
            SK_SRA:  r = {v[0], v[7], v[7:1]};
            SK_SWAP: r = {1'b0, v[3:0], v[7:4]};
            default: r = {v[0], 1'b0, v[7:1]};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bsu_decode.sv
module bsu_decode
    import bsu_pkg::*;
(
    input  logic              prefixed,
    input  logic [BYTE_W-1:0] opcode,
    output op_t               op
);
    always_comb begin
        op.reg_code = opcode[2:0];
        if (prefixed) begin
            op.cls      = op_class_e'(opcode[7:6]);
            op.sel      = opcode[5:3];
            op.acc_mode = 1'b0;
            op.use_mem  = (opcode[2:0] == MEM_CODE);
        end else begin
            op.cls      = CLS_SHIFT;
            op.sel      = {1'b0, opcode[4:3]};
            op.acc_mode = 1'b1;
            op.use_mem  = 1'b0;
        end
    end
endmodule

// File: rtl/bsu_alu.sv
module bsu_alu
    import bsu_pkg::*;
(
    input  op_t               op,
    input  logic [BYTE_W-1:0] operand,
    input  flags_t            fin,
    output exec_t             res
);
    logic [BYTE_W:0]   shifted;
    logic [BYTE_W-1:0] bit_mask;

    assign shifted  = shift_byte(shift_kind_e'(op.sel), operand, fin.c);
    assign bit_mask = {{(BYTE_W-1){1'b0}}, 1'b1} << op.sel;

    always_comb begin
        res.value    = operand;
        res.write    = 1'b1;
        res.flags    = fin;
        res.flags_we = 1'b0;
        case (op.cls)
            CLS_SHIFT: begin
                res.value    = shifted[BYTE_W-1:0];
                res.flags_we = 1'b1;
                res.flags.z  = !op.acc_mode && (shifted[BYTE_W-1:0] == '0);
                res.flags.n  = 1'b0;
                res.flags.h  = 1'b0;
                res.flags.c  = shifted[BYTE_W];
            end
            CLS_TEST: begin
                res.write    = 1'b0;
                res.flags_we = 1'b1;
                res.flags.z  = (operand & bit_mask) == '0;
                res.flags.n  = 1'b0;
                res.flags.h  = 1'b1;
            end
            CLS_CLEAR: res.value = operand & ~bit_mask;
            default:   res.value = operand | bit_mask;
        endcase
    end
endmodule

// File: rtl/bsu_ctrl.sv
module bsu_ctrl
    import bsu_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic use_mem,
    input  logic is_test,
    output logic accept,
    output logic busy,
    output logic load_phase,
    output logic exec_phase,
    output logic store_phase,
    output logic done
);
    seq_state_e state, nxt;

    assign accept      = start && (state == ST_IDLE);
    assign busy        = (state != ST_IDLE);
    assign load_phase  = (state == ST_LOAD);
    assign exec_phase  = (state == ST_EXEC);
    assign store_phase = (state == ST_STORE);
    assign done        = (state == ST_DONE);

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:  if (start) nxt = use_mem ? ST_LOAD : ST_DONE;
            ST_LOAD:  nxt = ST_EXEC;
            ST_EXEC:  nxt = is_test ? ST_STALL : ST_STORE;
            ST_STORE: nxt = ST_DONE;
            ST_STALL: nxt = ST_DONE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    assert_load_then_exec_R8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOAD) |=> (state == ST_EXEC));
    assert_exec_leaves_R8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EXEC) |=> (state == ST_STORE || state == ST_STALL));
endmodule

// File: rtl/bit_shift_unit.sv
module bit_shift_unit
    import bsu_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              prefixed,
    input  logic [7:0]        opcode,
    input  logic [7:0]        reg_data,
    input  logic [ADDR_W-1:0] hl_addr,
    input  logic [3:0]        flags_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    input  logic [7:0]        mem_rdata,
    output logic              mem_wr,
    output logic [7:0]        mem_wdata,
    output logic              busy,
    output logic              done,
    output logic [7:0]        result,
    output logic              reg_we,
    output logic [2:0]        reg_sel,
    output logic [3:0]        flags_out,
    output logic              flags_we
);
    op_t               op_dec, op_q, alu_op;
    flags_t            flags_q, alu_fl;
    logic [ADDR_W-1:0] addr_q;
    logic [BYTE_W-1:0] alu_in;
    exec_t             alu_out, res_q;
    logic              accept, exec_phase, load_phase, store_phase;

    bsu_decode u_dec (
        .prefixed (prefixed),
        .opcode   (opcode),
        .op       (op_dec)
    );

    bsu_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .use_mem     (op_dec.use_mem),
        .is_test     (op_q.cls == CLS_TEST),
        .accept      (accept),
        .busy        (busy),
        .load_phase  (load_phase),
        .exec_phase  (exec_phase),
        .store_phase (store_phase),
        .done        (done)
    );

    // One ALU: fed from the ports on a register request, from memory later
    assign alu_op = accept ? op_dec : op_q;
    assign alu_in = accept ? reg_data : mem_rdata;
    assign alu_fl = accept ? flags_t'(flags_in) : flags_q;

    bsu_alu u_alu (
        .op      (alu_op),
        .operand (alu_in),
        .fin     (alu_fl),
        .res     (alu_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q    <= '0;
            flags_q <= '0;
            addr_q  <= '0;
            res_q   <= '0;
        end else begin
            if (accept) begin
                op_q    <= op_dec;
                flags_q <= flags_t'(flags_in);
                addr_q  <= hl_addr;
                if (!op_dec.use_mem) res_q <= alu_out;
            end else if (exec_phase) begin
                res_q <= alu_out;
            end
        end
    end

    assign mem_addr  = addr_q;
    assign mem_rd    = load_phase;
    assign mem_wr    = store_phase;
    assign mem_wdata = res_q.value;
    assign result    = res_q.value;
    assign reg_sel   = op_q.reg_code;
    assign reg_we    = done && res_q.write && !op_q.use_mem;
    assign flags_we  = done && res_q.flags_we;
    assign flags_out = res_q.flags;

    assert_rw_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));
    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_acc_zero_flag_R7: assert property (@(posedge clk) disable iff (rst)
        (done && op_q.acc_mode) |-> !flags_out[3]);
    assert_test_no_store_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && op_q.cls == CLS_TEST) |-> !mem_wr);
    assert_bitforce_no_flags_R6: assert property (@(posedge clk) disable iff (rst)
        (done && (op_q.cls == CLS_CLEAR || op_q.cls == CLS_SET)) |-> !flags_we);
    assert_busy_holds_op_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(op_q));
endmodule

// File: tb/bit_shift_unit_test.sv
`timescale 1ns/1ps
module bit_shift_unit_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        start, prefixed;
    logic [7:0]  opcode, reg_data, mem_rdata, mem_wdata, result;
    logic [15:0] hl_addr, mem_addr;
    logic [3:0]  flags_in, flags_out;
    logic        mem_rd, mem_wr, busy, done, reg_we, flags_we;
    logic [2:0]  reg_sel;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int wr_count = 0;
    logic [7:0] mem_byte;

    always #2.5 clk = ~clk;

    bit_shift_unit uut (
        .clk(clk), .rst(rst), .start(start), .prefixed(prefixed), .opcode(opcode),
        .reg_data(reg_data), .hl_addr(hl_addr), .flags_in(flags_in),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .busy(busy), .done(done),
        .result(result), .reg_we(reg_we), .reg_sel(reg_sel),
        .flags_out(flags_out), .flags_we(flags_we)
    );

    // Memory model: one byte cell, read data one cycle after the strobe
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem_byte;
        if (mem_wr) wr_count <= wr_count + 1;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired: actual %0d cycles expected < 100000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Reference: returns {result[7:0], write, flags[3:0], flags_we}
    function automatic logic [13:0] ref_calc(input bit pref, input logic [7:0] opc,
                                             input logic [7:0] v, input logic [3:0] fin);
        int kind, cls, b;
        logic [7:0] r;
        logic c, wr, fwe;
        logic [3:0] f;
        r = v; c = fin[0]; f = fin; wr = 1'b1; fwe = 1'b0;
        cls  = pref ? int'(opc[7:6]) : 0;
        kind = pref ? int'(opc[5:3]) : int'(opc[4:3]);
        b    = int'(opc[5:3]);
        if (cls == 0) begin
            if (kind == 0) begin c = v[7]; r = (v << 1) | (v >> 7); end
            else if (kind == 1) begin c = v[0]; r = (v >> 1) | (v << 7); end
            else if (kind == 2) begin r = (v << 1) | {7'd0, fin[0]}; c = v[7]; end
            else if (kind == 3) begin r = (v >> 1) | {fin[0], 7'd0}; c = v[0]; end
            else if (kind == 4) begin c = v[7]; r = v << 1; end
            else if (kind == 5) begin c = v[0]; r = (v >> 1) | (v & 8'h80); end
            else if (kind == 6) begin c = 1'b0; r = {v[3:0], v[7:4]}; end
            else begin c = v[0]; r = v >> 1; end
            f = {pref && (r == 8'h00), 1'b0, 1'b0, c};
            fwe = 1'b1;
        end else if (cls == 1) begin
            wr = 1'b0; fwe = 1'b1;
            f = {~v[b], 1'b0, 1'b1, fin[0]};
        end else if (cls == 2) begin
            r = v & ~(8'h01 << b);
        end else begin
            r = v | (8'h01 << b);
        end
        return {r, wr, f, fwe};
    endfunction

    task automatic run_op(input bit pref, input logic [7:0] opc, input logic [7:0] rv,
                          input logic [7:0] mv, input logic [15:0] addr,
                          input logic [3:0] fin, input bit poke, input string tag);
        logic [13:0] e;
        bit mem_op;
        int w0;
        mem_op = pref && (opc[2:0] == 3'd6);
        e = ref_calc(pref, opc, mem_op ? mv : rv, fin);
        mem_byte = mv;
        w0 = wr_count;
        @(negedge clk);
        start = 1'b1; prefixed = pref; opcode = opc; reg_data = rv;
        hl_addr = addr; flags_in = fin;
        @(negedge clk);
        start = 1'b0;
        if (mem_op) begin
            chk(mem_rd == 1'b1 && mem_wr == 1'b0 && done == 1'b0, {tag, " R8 read cycle"}, mem_rd, 1);
            chk(mem_addr == addr, {tag, " R8 address"}, mem_addr, addr);
            if (poke) begin
                start = 1'b1; prefixed = 1'b1; opcode = 8'hC0; reg_data = 8'h00;
            end
            @(negedge clk);
            start = 1'b0;
            chk(mem_rd == 1'b0 && mem_wr == 1'b0 && done == 1'b0 && busy == 1'b1,
                {tag, " R8 operate cycle"}, {mem_rd, mem_wr, done}, 0);
            @(negedge clk);
            if (e[5]) begin
                chk(mem_wr == 1'b1, {tag, " R8 store strobe"}, mem_wr, 1);
                chk(mem_wdata == e[13:6], {tag, " R8 store data"}, mem_wdata, e[13:6]);
            end else begin
                chk(mem_wr == 1'b0 && done == 1'b0, {tag, " R5 test stall, no store"}, mem_wr, 0);
            end
            @(negedge clk);
            chk(done == 1'b1 && reg_we == 1'b0, {tag, " R8 done, no register write"},
                {done, reg_we}, 2);
            chk(wr_count - w0 == (e[5] ? 1 : 0), {tag, " R5/R8 write count"}, wr_count - w0, e[5]);
        end else begin
            chk(done == 1'b1, {tag, " R9 done timing"}, done, 1);
            chk(result == e[13:6], {tag, " R2/R3/R6 result"}, result, e[13:6]);
            chk(reg_we == e[5], {tag, " R5/R9 reg_we"}, reg_we, e[5]);
            chk(reg_sel == opc[2:0], {tag, " R1 reg_sel"}, reg_sel, opc[2:0]);
        end
        chk(flags_we == e[0], {tag, " R4/R6 flags_we"}, flags_we, e[0]);
        chk(flags_out == e[4:1], {tag, " R4/R5/R7 flags"}, flags_out, e[4:1]);
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, {tag, " R9/R10 back to idle"}, {done, busy}, 0);
        if (poke) begin
            @(negedge clk);
            chk(done == 1'b0 && reg_we == 1'b0, {tag, " R10 ignored start"}, {done, reg_we}, 0);
        end
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; prefixed = 1'b1; opcode = 8'h00;
        reg_data = 8'h00; hl_addr = 16'h0000; flags_in = 4'h0;
        mem_rdata = 8'h00; mem_byte = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 0 && done == 0 && mem_rd == 0 && mem_wr == 0 && reg_we == 0 && flags_we == 0,
            "R11 reset idle", {busy, done, mem_rd, mem_wr, reg_we, flags_we}, 0);

        // R2 rotates
        run_op(1, 8'h00, 8'h85, 8'h00, 16'h0, 4'h0, 0, "R2 rlc");
        run_op(1, 8'h09, 8'h01, 8'h00, 16'h0, 4'h0, 0, "R2 rrc");
        run_op(1, 8'h12, 8'h80, 8'h00, 16'h0, 4'h0, 0, "R2 rl zero");
        run_op(1, 8'h1B, 8'h01, 8'h00, 16'h0, 4'h1, 0, "R2 rr carry in");
        // R3 shifts and swap
        run_op(1, 8'h24, 8'h80, 8'h00, 16'h0, 4'h0, 0, "R3 sla");
        run_op(1, 8'h2D, 8'h81, 8'h00, 16'h0, 4'h0, 0, "R3 sra");
        run_op(1, 8'h37, 8'hF1, 8'h00, 16'h0, 4'h1, 0, "R3 swap");
        run_op(1, 8'h38, 8'h01, 8'h00, 16'h0, 4'h0, 0, "R3 srl");
        // R5 bit test, R6 clear / set
        run_op(1, 8'h78, 8'h7F, 8'h00, 16'h0, 4'h1, 0, "R5 bit7 clear");
        run_op(1, 8'h41, 8'h01, 8'h00, 16'h0, 4'h8, 0, "R5 bit0 set");
        run_op(1, 8'h9A, 8'hFF, 8'h00, 16'h0, 4'hA, 0, "R6 clear bit3");
        run_op(1, 8'hEF, 8'h00, 8'h00, 16'h0, 4'h5, 0, "R6 set bit5");
        // R7 accumulator rotates vs prefixed twin
        run_op(0, 8'h07, 8'h00, 8'h00, 16'h0, 4'h8, 0, "R7 acc rlc zero");
        run_op(1, 8'h07, 8'h00, 8'h00, 16'h0, 4'h0, 0, "R4 prefixed rlc zero");
        run_op(0, 8'h1F, 8'h01, 8'h00, 16'h0, 4'h0, 0, "R7 acc rr");
        run_op(0, 8'h17, 8'h80, 8'h00, 16'h0, 4'h1, 0, "R7 acc rl");
        run_op(0, 8'h0F, 8'h01, 8'h00, 16'h0, 4'h0, 0, "R7 acc rrc");
        // R8 memory operand sequences
        run_op(1, 8'h16, 8'h00, 8'hC3, 16'hC012, 4'h1, 0, "R8 mem rl");
        run_op(1, 8'hFE, 8'h00, 8'h01, 16'h8001, 4'h0, 0, "R8 mem set7");
        run_op(1, 8'h56, 8'h00, 8'h04, 16'hFF80, 4'h0, 0, "R5 mem bit2");
        run_op(1, 8'h36, 8'h00, 8'hA5, 16'h1234, 4'h0, 1, "R10 mem swap busy poke");
        // R1 sweep of the whole register-operand prefixed space
        for (int i = 0; i < 256; i++) begin
            if (i[2:0] != 3'd6)
                run_op(1, 8'(i), 8'(i * 37 + 11), 8'h00, 16'h0, 4'(i), 0, "R1 sweep");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule